// File: doc/BRIEF.md
# Selectable CIC Decimator with Pre-Filter Gain Shifter

This block lowers the sample rate of a stream of signed 10-bit samples. Each sample that arrives with its valid strobe first goes through a power-of-two gain stage. That stage shifts the sample left by a programmable amount and clamps the result to a 16-bit signed word. The clamped word then feeds one of three paths, chosen at run time by a 2-bit mode field: a three-stage cascaded integrator-comb decimator, a single-stage integrate-and-dump accumulator, or a pass-through. Every output word leaves the block with its own valid strobe.

The gain setting is meant to bring small signals up to a useful level without clipping. When a setting does clip, the sample is held at the 16-bit rail and a sticky flag records the event, so the setting can be corrected. The decimation factor and the mode may change while the block runs. Any such change discards all filter history, so each new configuration starts from a clean state.

Top module: `cic_decim_shift`

## Requirements
- R1: While reset is asserted and after it is released, before any sample is accepted, `out_valid_o` is 0, `out_data_o` is 0 and `ovf_o` is 0.
- R2: Each sample `in_data_i` (10-bit two's complement) is multiplied by 2^`shift_i` (`shift_i` from 0 to 63). The product is clamped to the signed 16-bit range [-32768, 32767]. A product that fits exactly, such as -512·2^6 = -32768, passes unchanged.
- R3: `ovf_o` goes high on the cycle after a valid sample whose product had to be clamped. It then stays high until reset.
- R4: With `mode_i` = 2'b10 or 2'b11 (pass-through), every accepted sample produces `out_valid_o` = 1 one cycle later. `out_data_o` then holds the clamped sample, sign-extended to 40 bits.
- R5: With `mode_i` = 2'b01 (integrate-and-dump) and factor R, the accepted samples are grouped in consecutive runs of R. One cycle after the last sample of a run, the block outputs the exact sum of that run's clamped samples. The next run starts its sum from zero.
- R6: With `mode_i` = 2'b00 (three-stage CIC) and factor R, accepted samples x[n] are numbered from the last state clear. One cycle after sample n = mR+R-1, the output is Σ h[k]·x[n-k], where h is the impulse response of (1+z^-1+…+z^-(R-1))^3 and samples before the clear count as 0. The sum is computed exactly in 40-bit two's complement.
- R7: A decimation factor `dec_i` of 0 is treated as 1.
- R8: On a cycle where `mode_i` or `dec_i` differs from its value on the previous cycle, all integrator, comb, accumulator and count state is cleared. A sample offered on that same cycle is discarded and produces no output. Counting restarts with the next sample.
- R9: `out_valid_o` is high only on the cycle after an accepted sample completes an output. Between outputs, `out_data_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | 10 | Signed input sample |
| mode_i | input | 2 | 00 three-stage CIC, 01 integrate-and-dump, 1x pass-through |
| dec_i | input | 8 | Decimation factor R (0 means 1) |
| shift_i | input | 6 | Gain exponent N, gain 2^N |
| out_valid_o | output | 1 | Output word strobe |
| out_data_o | output | 40 | Signed decimated output |
| ovf_o | output | 1 | Sticky clamp indicator |

## Verification
A wrong integrator or comb register in the CIC path does not show on the ports until the next decimated output. That output appears up to R accepted samples later, and the error then persists in every later word. A stale integrate-and-dump accumulator shows up as an offset in the word that follows the dump. A count that is off by one shows within one run as an output strobe in the wrong cycle. For these reasons the reference model compares the strobe, the data and the flag on every cycle, with runs of gaps and mid-stream configuration changes, so that each fault is caught at the first output it can affect.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam logic [1:0] MODE_CIC3 = 2'b00;
    localparam logic [1:0] MODE_IAD  = 2'b01;

    // Upper mode bit set selects the pass-through path.
    function automatic logic mode_is_bypass(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/cic_gain_shift.sv
module cic_gain_shift #(
    parameter int IN_W    = 10,
    parameter int SHIFT_W = 6,
    parameter int SAT_W   = 16
) (
    input  logic [IN_W-1:0]    din_i,
    input  logic [SHIFT_W-1:0] sh_i,
    output logic [SAT_W-1:0]   x_o,
    output logic               sat_o
);

    // Wide enough that the largest shift never loses a bit.
    localparam int WIDE_W = IN_W + (1 << SHIFT_W) - 1;
    localparam int HI_W   = WIDE_W - SAT_W + 1;
    localparam logic [SAT_W-1:0] SAT_MAX = {1'b0, {(SAT_W-1){1'b1}}};
    localparam logic [SAT_W-1:0] SAT_MIN = {1'b1, {(SAT_W-1){1'b0}}};

    logic [WIDE_W-1:0] ext;
    logic [WIDE_W-1:0] shl;
    logic [HI_W-1:0]   hi;
    logic              fits;

    always_comb begin
        ext   = {{(WIDE_W-IN_W){din_i[IN_W-1]}}, din_i};
        shl   = ext << sh_i;
        // Result fits when every bit above the target sign bit copies it.
        hi    = shl[WIDE_W-1:SAT_W-1];
        fits  = (&hi) | ~(|hi);
        sat_o = ~fits;
        if (fits) begin
            x_o = shl[SAT_W-1:0];
        end else if (shl[WIDE_W-1]) begin
            x_o = SAT_MIN;
        end else begin
            x_o = SAT_MAX;
        end
    end

endmodule

// File: rtl/cic_dec_ctrl.sv
module cic_dec_ctrl #(
    parameter int DEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       mode_i,
    input  logic [DEC_W-1:0] dec_i,
    output logic             take_o,
    output logic             dump_o,
    output logic             clear_o
);
    import cic_pkg::*;

    typedef struct packed {
        logic             cfg_vld;
        logic [1:0]       mode;
        logic [DEC_W-1:0] dec;
        logic [DEC_W-1:0] cnt;
    } ctl_t;

    ctl_t             st_q;
    ctl_t             st_d;
    logic [DEC_W-1:0] r_last;

    always_comb begin
        // Factor zero behaves as one: every sample closes a run.
        r_last  = (dec_i == '0) ? '0 : dec_i - DEC_W'(1);
        clear_o = st_q.cfg_vld && ((mode_i != st_q.mode) || (dec_i != st_q.dec));
        take_o  = valid_i && !clear_o;
        dump_o  = take_o && (mode_is_bypass(mode_i) || (st_q.cnt == r_last));

        st_d         = st_q;
        st_d.cfg_vld = 1'b1;
        st_d.mode    = mode_i;
        st_d.dec     = dec_i;
        if (clear_o) begin
            st_d.cnt = '0;
        end else if (take_o) begin
            st_d.cnt = dump_o ? '0 : st_q.cnt + DEC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5 / R6: run position never passes the last slot of a run
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg_vld && !clear_o) |-> (st_q.cnt <= r_last));

    // R8: a configuration change restarts the run count
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/cic_filt.sv
module cic_filt #(
    parameter int SAT_W  = 16,
    parameter int OUT_W  = 40,
    parameter int NSTAGE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SAT_W-1:0] x_i,
    input  logic [1:0]       mode_i,
    input  logic             take_i,
    input  logic             dump_i,
    input  logic             clear_i,
    output logic             out_valid_o,
    output logic [OUT_W-1:0] out_data_o
);
    import cic_pkg::*;

    typedef struct packed {
        logic [NSTAGE-1:0][OUT_W-1:0] integ;
        logic [NSTAGE-1:0][OUT_W-1:0] dly;
        logic [OUT_W-1:0]             acc;
        logic                         out_valid;
        logic [OUT_W-1:0]             out_data;
    } filt_t;

    filt_t            st_q;
    filt_t            st_d;
    logic [OUT_W-1:0] xe;
    logic [OUT_W-1:0] acc_n;
    logic [OUT_W-1:0] isum  [NSTAGE];
    logic [OUT_W-1:0] cdiff [NSTAGE];

    assign xe    = {{(OUT_W-SAT_W){x_i[SAT_W-1]}}, x_i};
    assign acc_n = st_q.acc + xe;

    // Integrator chain includes the current sample; combs work on the
    // decimated integrator output with unit differential delay.
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign isum[s]  = st_q.integ[s] + xe;
            assign cdiff[s] = isum[NSTAGE-1] - st_q.dly[s];
        end else begin : g_rest
            assign isum[s]  = st_q.integ[s] + isum[s-1];
            assign cdiff[s] = cdiff[s-1] - st_q.dly[s];
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (clear_i) begin
            st_d.integ = '0;
            st_d.dly   = '0;
            st_d.acc   = '0;
        end else if (take_i) begin
            if (mode_is_bypass(mode_i)) begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = xe;
            end else if (mode_i == MODE_IAD) begin
                if (dump_i) begin
                    st_d.out_valid = 1'b1;
                    st_d.out_data  = acc_n;
                    st_d.acc       = '0;
                end else begin
                    st_d.acc = acc_n;
                end
            end else begin
                for (int s = 0; s < NSTAGE; s++) begin
                    st_d.integ[s] = isum[s];
                end
                if (dump_i) begin
                    st_d.dly[0] = isum[NSTAGE-1];
                    for (int s = 1; s < NSTAGE; s++) begin
                        st_d.dly[s] = cdiff[s-1];
                    end
                    st_d.out_valid = 1'b1;
                    st_d.out_data  = cdiff[NSTAGE-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.out_valid;
    assign out_data_o  = st_q.out_data;

    // R8: the cycle of a configuration change never yields an output
    a_r8_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !out_valid_o);

    // R5: a dump leaves the accumulator empty for the next run
    a_r5_dump_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && dump_i && (mode_i == MODE_IAD)) |=> (st_q.acc == '0));

    // R6: a filtering sample that does not close a run emits nothing
    a_r6_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !dump_i && !mode_is_bypass(mode_i)) |=> !out_valid_o);

endmodule

// File: rtl/cic_decim_shift.sv
module cic_decim_shift
    import cic_pkg::*;
#(
    parameter  int IN_W    = 10,
    parameter  int SHIFT_W = 6,
    parameter  int SAT_W   = 16,
    parameter  int DEC_W   = 8,
    parameter  int NSTAGE  = 3,
    localparam int OUT_W   = SAT_W + NSTAGE * DEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [IN_W-1:0]    in_data_i,
    input  logic [1:0]         mode_i,
    input  logic [DEC_W-1:0]   dec_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               out_valid_o,
    output logic [OUT_W-1:0]   out_data_o,
    output logic               ovf_o
);

    localparam logic [SAT_W-1:0] SAT_MAX = {1'b0, {(SAT_W-1){1'b1}}};
    localparam logic [SAT_W-1:0] SAT_MIN = {1'b1, {(SAT_W-1){1'b0}}};

    typedef struct packed {
        logic ovf;
    } top_t;

    top_t             st_q;
    top_t             st_d;
    logic [SAT_W-1:0] x_sat;
    logic             sat;
    logic             take;
    logic             dump;
    logic             clear;
    logic [OUT_W-1:0] x_ext;

    cic_gain_shift #(
        .IN_W   (IN_W),
        .SHIFT_W(SHIFT_W),
        .SAT_W  (SAT_W)
    ) u_gain (
        .din_i(in_data_i),
        .sh_i (shift_i),
        .x_o  (x_sat),
        .sat_o(sat)
    );

    cic_dec_ctrl #(
        .DEC_W(DEC_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(in_valid_i),
        .mode_i (mode_i),
        .dec_i  (dec_i),
        .take_o (take),
        .dump_o (dump),
        .clear_o(clear)
    );

    cic_filt #(
        .SAT_W (SAT_W),
        .OUT_W (OUT_W),
        .NSTAGE(NSTAGE)
    ) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .x_i        (x_sat),
        .mode_i     (mode_i),
        .take_i     (take),
        .dump_i     (dump),
        .clear_i    (clear),
        .out_valid_o(out_valid_o),
        .out_data_o (out_data_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = st_q.ovf | (in_valid_i & sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o = st_q.ovf;
    assign x_ext = {{(OUT_W-SAT_W){x_sat[SAT_W-1]}}, x_sat};

    // R2: a clamped sample sits on one of the two rails
    a_r2_clamp_on_rail: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> ((x_sat == SAT_MAX) || (x_sat == SAT_MIN)));

    // R3: the flag never drops once raised
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R3: a clamped valid sample raises the flag next cycle
    a_r3_ovf_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && sat) |=> ovf_o);

    // R4: pass-through echoes the gained sample one cycle later
    a_r4_bypass_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_is_bypass(mode_i)) |=> (out_valid_o && (out_data_o == $past(x_ext))));

    // R9: no output strobe without a sample on the previous cycle
    a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i));

endmodule

// File: tb/cic_decim_shift_tb.sv
module cic_decim_shift_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_data = '0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  dec = '0;
    logic [5:0]  shift = '0;
    logic        out_valid;
    logic [39:0] out_data;
    logic        ovf;

    always #4 clk = ~clk;

    cic_decim_shift u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .in_data_i  (in_data),
        .mode_i     (mode),
        .dec_i      (dec),
        .shift_i    (shift),
        .out_valid_o(out_valid),
        .out_data_o (out_data),
        .ovf_o      (ovf)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    bit     seen = 0;
    int     pmode = 0;
    int     pdec = 0;
    int     cnt = 0;
    longint acc = 0;
    longint hist[$];
    bit     exp_valid = 0;
    longint exp_data = 0;
    bit     exp_ovf = 0;
    string  exp_req = "R1";

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint hcoef(input int k, input int r);
        longint c = 0;
        for (int a = 0; a < r; a++)
            for (int b = 0; b < r; b++)
                if ((k - a - b) >= 0 && (k - a - b) < r) c++;
        return c;
    endfunction

    task automatic gain_model(input int din, input int n, output longint v, output bit s);
        longint raw;
        s = 0;
        if (din == 0) begin
            v = 0;
        end else if (n >= 20) begin
            v = (din > 0) ? 32767 : -32768;
            s = 1;
        end else begin
            raw = longint'(din) <<< n;
            if (raw > 32767) begin v = 32767; s = 1; end
            else if (raw < -32768) begin v = -32768; s = 1; end
            else v = raw;
        end
    endtask

    // Check outputs of the last edge, apply new inputs, advance the model.
    task automatic drive(input bit v, input int d, input int m, input int dv, input int sh);
        bit     clr;
        bit     s;
        longint x;
        int     r;
        longint y;
        int     n;
        chk(exp_valid ? exp_req : (exp_req == "R8" ? "R8" : "R9"), "out_valid",
            longint'(out_valid), longint'(exp_valid));
        chk(exp_valid ? exp_req : "R9", "out_data", longint'($signed(out_data)), exp_data);
        chk("R3", "ovf", longint'(ovf), longint'(exp_ovf));

        in_valid = v;
        in_data  = d[9:0];
        mode     = m[1:0];
        dec      = dv[7:0];
        shift    = sh[5:0];

        exp_valid = 0;
        exp_req   = "R9";
        clr = 0;
        if (!seen) seen = 1;
        else clr = (m != pmode) || (dv != pdec);
        pmode = m;
        pdec  = dv;
        gain_model(int'($signed(d[9:0])), sh, x, s);
        if (v && s) exp_ovf = 1;
        if (clr) begin
            cnt = 0;
            acc = 0;
            hist.delete();
            exp_req = "R8";
        end else if (v) begin
            r = (dv == 0) ? 1 : dv;
            if (m >= 2) begin
                exp_valid = 1;
                exp_data  = x;
                exp_req   = "R2,R4";
            end else if (m == 1) begin
                acc += x;
                cnt++;
                if (cnt == r) begin
                    exp_valid = 1;
                    exp_data  = acc;
                    exp_req   = (dv == 0) ? "R7" : "R5";
                    acc = 0;
                    cnt = 0;
                end
            end else begin
                hist.push_back(x);
                cnt++;
                if (cnt == r) begin
                    n = hist.size() - 1;
                    y = 0;
                    for (int k = 0; k <= 3 * (r - 1); k++)
                        if (n - k >= 0) y += hcoef(k, r) * hist[n - k];
                    exp_valid = 1;
                    exp_data  = y;
                    exp_req   = (dv <= 1) ? "R6,R7" : "R6";
                    cnt = 0;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic run_random(input int m, input int dv, input int len, input int maxsh, input int gap_pct);
        for (int i = 0; i < len; i++) begin
            bit vv;
            vv = ($urandom_range(0, 99) >= gap_pct);
            drive(vv, int'($urandom_range(0, 1023)), m, dv, int'($urandom_range(0, maxsh)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "out_valid", longint'(out_valid), 0);
            chk("R1", "out_data", longint'($signed(out_data)), 0);
            chk("R1", "ovf", longint'(ovf), 0);
        end
        rst_n = 1'b1;
        drive(0, 0, 2, 3, 0);

        // R2/R4: pass-through with shifts that fit, including the exact rail
        drive(1, 5, 2, 3, 0);
        drive(1, 1017, 2, 3, 0);      // -7
        drive(1, 511, 2, 3, 6);       // 32704, fits
        drive(1, 512, 2, 3, 6);       // -512 * 64 = -32768, fits
        drive(1, 0, 2, 3, 63);        // zero never clamps
        drive(0, 33, 2, 3, 0);
        drive(0, 34, 2, 3, 0);        // R9 hold
        drive(1, 511, 2, 3, 7);       // R3 clamp to max
        drive(1, 1023, 2, 3, 63);     // -1 clamps to min
        drive(0, 0, 2, 3, 0);
        run_random(3, 3, 20, 10, 30);

        // R5: integrate-and-dump, then factor 0 (R7)
        run_random(1, 4, 40, 5, 25);
        run_random(1, 0, 10, 5, 20);
        // R8: change with a sample on the change cycle
        run_random(1, 3, 20, 5, 0);

        // R6: three-stage CIC with several factors
        run_random(0, 5, 80, 5, 20);
        run_random(0, 1, 12, 5, 0);
        run_random(0, 8, 120, 6, 30);
        for (int i = 0; i < 40; i++) drive(1, 511, 0, 8, 6);
        run_random(1, 8, 20, 5, 0);   // R8 mode change mid-stream
        run_random(0, 8, 40, 5, 10);
        run_random(0, 2, 30, 5, 10);
        drive(0, 0, 0, 2, 0);
        drive(0, 0, 0, 2, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule